// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

This block watches one tearing-effect pin driven by a display panel and decides when a frame transfer may start. The panel sends both its horizontal and its vertical sync on that one pin, so the block tells them apart only by how long each pulse stays active. Pulse widths are counted in ticks of a divided clock. A pulse at or above the vertical minimum counts as vertical sync. A shorter pulse that still reaches the horizontal minimum counts as horizontal sync. Anything shorter is ignored.

A transfer engine pulses `arm_i` when it wants to start a frame. If tearing-effect gating is off, the transfer is released on the next cycle. If gating is on, the block waits for the selected sync condition, then emits a single-cycle `match_o` and raises `xfer_en_o`. In frame mode the condition is a vertical pulse. In line mode a counter is cleared by each vertical pulse and advanced by each horizontal pulse, and the condition is met when the counter reaches the programmed line. Exactly one match is produced per arming.

Top module: `te_sync_detect`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `match_o` and `xfer_en_o` are 0.
- R2: Gating is on only when `te_en_i`=1 and `mode_i` is 2 (line) or 3 (frame). Values 0 and 1 mean off. If gating is off when `arm_i` is sampled, `xfer_en_o` is 1 on the next cycle, and no `match_o` follows from that arming.
- R3: In mode 3, an armed detector matches on a pulse whose active width is at least (`vs_width_i`+1)*8 ticks. A shorter pulse does not match. On a match, `match_o` and `xfer_en_o` go high in the same cycle.
- R4: A pulse whose active width is below `hs_width_i`+1 ticks is ignored: it neither advances the line count nor matches.
- R5: In mode 2 with `line_i`≠0, a vertical pulse clears the line count. Each horizontal pulse (width in [`hs_width_i`+1, vertical minimum) ticks) adds one. An armed detector matches on the horizontal pulse that brings the count to `line_i`. In this case vertical pulses do not match.
- R6: In mode 2 with `line_i`=0, the detector behaves as in mode 3: horizontal pulses never match, and a vertical pulse does.
- R7: `vs_inv_i`=1 makes a low level active for vertical measurement, and `hs_inv_i`=1 does the same for horizontal measurement. With the bit at 0, a high level is active.
- R8: After a match, further sync pulses produce no `match_o`, and `xfer_en_o` stays 1 until the next `arm_i`. An arming with gating on drives `xfer_en_o` to 0 on the next cycle.
- R9: If `arm_i` is high in the same cycle that a qualifying pulse ends, no match is produced and the detector stays armed for the next qualifying pulse.
- R10: One tick lasts `div_i`+1 clock cycles, so the tick divider ranges from 1 to 8.
- R11: `match_o` is never high on two consecutive cycles. It rises only together with `xfer_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| div_i | input | 3 | Tick divider minus one |
| hs_inv_i | input | 1 | Invert pin for horizontal measurement |
| vs_inv_i | input | 1 | Invert pin for vertical measurement |
| hs_width_i | input | 3 | Horizontal minimum width in ticks, minus one |
| vs_width_i | input | 9 | Vertical minimum width in units of 8 ticks, minus one |
| mode_i | input | 2 | 0/1 off, 2 line mode, 3 frame mode |
| line_i | input | 11 | Target line count for mode 2 |
| te_en_i | input | 1 | Tearing-effect logic enable |
| arm_i | input | 1 | Transfer start request, one cycle |
| match_o | output | 1 | Single-cycle sync match pulse |
| xfer_en_o | output | 1 | Transfer may proceed |

## Verification
The end of a qualifying sync pulse and a new `arm_i` can land on the same cycle. The design settles this in favour of the re-arm. The bench provokes the collision on purpose. It ends a vertical pulse, counts the two synchroniser stages, and then asserts `arm_i` exactly in the cycle where the pulse-end event is evaluated. The collision is judged correct if no match pulse appears, `xfer_en_o` stays low, and the next vertical pulse still produces one match. Random pulse trains with both polarities, all modes and several target lines are checked against a bench model of the line counter and the arming state.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RSVD  = 2'd1,
    MODE_LINE  = 2'd2,
    MODE_FRAME = 2'd3
  } te_mode_e;

  localparam int HS_IDX = 0;
  localparam int VS_IDX = 1;
endpackage

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  assign tick_o = (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pre_q <= '0;
    else if (tick_o || pre_q > div_i)  pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/te_width_meas.sv
module te_width_meas #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             tick_i,
  output logic             end_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (!lvl_i)                          cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // active-to-inactive edge; cnt_q still holds the finished width
  assign end_o   = lvl_q & ~lvl_i;
  assign width_o = cnt_q;
endmodule

// File: rtl/te_line_track.sv
module te_line_track #(
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vs_evt_i,
  input  logic              hs_evt_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              hit_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == LINE_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hit_o   = hs_evt_i && (cnt_inc == line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || vs_evt_i) cnt_q <= '0;
    else if (hs_evt_i)          cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int HS_W   = 3,
  parameter int VS_W   = 9,
  parameter int LINE_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              te_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              hs_inv_i,
  input  logic              vs_inv_i,
  input  logic [HS_W-1:0]   hs_width_i,
  input  logic [VS_W-1:0]   vs_width_i,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              te_en_i,
  input  logic              arm_i,
  output logic              match_o,
  output logic              xfer_en_o
);
  localparam int VMIN_W = VS_W + 4;
  localparam int CMP_W  = (VMIN_W > CNT_W + 1) ? VMIN_W : CNT_W + 1;

  te_mode_e mode;
  assign mode = te_mode_e'(mode_i);

  // two-stage pin synchroniser
  logic [1:0] sync_q;
  logic       pin_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], te_i};
  end
  assign pin_s = sync_q[1];

  logic tick;
  te_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .tick_o (tick)
  );

  logic [1:0]       inv, lvl, pend;
  logic [CNT_W-1:0] pw [2];
  assign inv = {vs_inv_i, hs_inv_i};

  for (genvar g = 0; g < 2; g++) begin : g_meas
    assign lvl[g] = pin_s ^ inv[g];
    te_width_meas #(.CNT_W(CNT_W)) u_meas (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (lvl[g]),
      .tick_i  (tick),
      .end_o   (pend[g]),
      .width_o (pw[g])
    );
  end

  logic [CMP_W-1:0] hs_min, vs_min, hs_w, vs_w;
  assign hs_min = CMP_W'(hs_width_i) + CMP_W'(1);
  assign vs_min = (CMP_W'(vs_width_i) + CMP_W'(1)) << 3;
  assign hs_w   = CMP_W'(pw[HS_IDX]);
  assign vs_w   = CMP_W'(pw[VS_IDX]);

  logic hs_evt, vs_evt;
  assign vs_evt = pend[VS_IDX] && (vs_w >= vs_min);
  assign hs_evt = pend[HS_IDX] && (hs_w >= hs_min) && (hs_w < vs_min);

  logic sync_on, vs_only, line_hit, trig, fire;
  assign sync_on = te_en_i && (mode == MODE_LINE || mode == MODE_FRAME);
  assign vs_only = (mode == MODE_FRAME) || (line_i == '0);

  te_line_track #(.LINE_W(LINE_W)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!sync_on),
    .vs_evt_i (vs_evt),
    .hs_evt_i (hs_evt),
    .line_i   (line_i),
    .hit_o    (line_hit)
  );

  assign trig = vs_only ? vs_evt : line_hit;
  // a fresh arm takes priority over an event of the same cycle
  assign fire = armed_q && sync_on && !arm_i && trig;

  logic armed_q, xfer_q, match_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      xfer_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= fire;
      if (arm_i) begin
        armed_q <= sync_on;
        xfer_q  <= !sync_on;
      end else if (fire) begin
        armed_q <= 1'b0;
        xfer_q  <= 1'b1;
      end
    end
  end

  assign match_o   = match_q;
  assign xfer_en_o = xfer_q;
endmodule

// File: rtl/te_sync_detect_chk.sv
module te_sync_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       te_en_i,
  input logic [1:0] mode_i,
  input logic       arm_i,
  input logic       match_o,
  input logic       xfer_en_o
);
  logic sync_on;
  assign sync_on = te_en_i && (mode_i == 2'd2 || mode_i == 2'd3);

  // R11
  match_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  // R11
  match_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $rose(xfer_en_o));

  // R3
  match_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> xfer_en_o);

  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !sync_on) |=> (xfer_en_o && !match_o));

  // R8
  rearm_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && sync_on) |=> !xfer_en_o);

  // R8
  release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_en_o && !arm_i) |=> xfer_en_o);

  // R9
  arm_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !match_o);
endmodule

bind te_sync_detect te_sync_detect_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .te_en_i   (te_en_i),
  .mode_i    (mode_i),
  .arm_i     (arm_i),
  .match_o   (match_o),
  .xfer_en_o (xfer_en_o)
);

// File: tb/test_te_sync_detect.sv
`timescale 1ns/1ps
module test_te_sync_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        te_i = 1'b0;
  logic [2:0]  div_i = 3'd0;
  logic        hs_inv_i = 1'b0, vs_inv_i = 1'b0;
  logic [2:0]  hs_width_i = 3'd3;   // 4 ticks
  logic [8:0]  vs_width_i = 9'd1;   // 16 ticks
  logic [1:0]  mode_i = 2'd0;
  logic [10:0] line_i = '0;
  logic        te_en_i = 1'b0;
  logic        arm_i = 1'b0;
  logic        match_o, xfer_en_o;

  int n_chk = 0, n_err = 0;
  int seen = 0, run = 0, run_max = 0;
  logic idle = 1'b0;
  bit done = 1'b0;
  int lc = 0;

  always #4 clk_i = ~clk_i;

  te_sync_detect i_te_sync_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .te_i(te_i), .div_i(div_i),
    .hs_inv_i(hs_inv_i), .vs_inv_i(vs_inv_i), .hs_width_i(hs_width_i),
    .vs_width_i(vs_width_i), .mode_i(mode_i), .line_i(line_i),
    .te_en_i(te_en_i), .arm_i(arm_i), .match_o(match_o), .xfer_en_o(xfer_en_o)
  );

  always @(posedge clk_i) begin
    #2;
    if (match_o) begin
      seen++;
      run++;
      if (run > run_max) run_max = run;
    end else run = 0;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 short, 1 horizontal, 2 vertical (div 1, 4/16 tick thresholds)
  function automatic int classify(int w);
    if (w >= 16) return 2;
    if (w >= 4)  return 1;
    return 0;
  endfunction

  task automatic cfg(int md, int en, int ln, logic pol);
    @(negedge clk_i);
    mode_i = 2'(md); te_en_i = en[0]; line_i = 11'(ln);
    hs_inv_i = pol; vs_inv_i = pol; idle = pol; te_i = pol;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic arm();
    arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
  endtask

  task automatic pulse(int w, int gap);
    te_i = ~idle;
    repeat (w) @(negedge clk_i);
    te_i = idle;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h7e5a_11c3);
    repeat (3) @(negedge clk_i);
    check("R1 match in reset", int'(match_o), 0);
    check("R1 xfer in reset", int'(xfer_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 match after reset", int'(match_o), 0);
    check("R1 xfer after reset", int'(xfer_en_o), 0);

    // R2: gating off variants
    cfg(3, 0, 0, 1'b0);
    seen = 0; arm();
    check("R2 te_en off xfer", int'(xfer_en_o), 1);
    pulse(20, 6); settle();
    check("R2 te_en off no match", seen, 0);
    cfg(1, 1, 0, 1'b0);
    arm();
    check("R2 mode1 xfer", int'(xfer_en_o), 1);
    cfg(0, 1, 0, 1'b0);
    arm();
    check("R2 mode0 xfer", int'(xfer_en_o), 1);

    // R3 boundary, R8 hold
    cfg(3, 1, 0, 1'b0);
    seen = 0; arm();
    check("R8 arm clears xfer", int'(xfer_en_o), 0);
    pulse(15, 6); settle();
    check("R3 width 15 no match", seen, 0);
    pulse(16, 6); settle();
    check("R3 width 16 match", seen, 1);
    check("R3 xfer after match", int'(xfer_en_o), 1);
    pulse(25, 6); settle();
    check("R8 no second match", seen, 1);
    check("R8 xfer held", int'(xfer_en_o), 1);

    // R4 boundary in line mode
    cfg(2, 1, 1, 1'b0);
    seen = 0; arm();
    pulse(20, 6);
    pulse(3, 6); settle();
    check("R4 width 3 ignored", seen, 0);
    pulse(4, 6); settle();
    check("R4 width 4 counted", seen, 1);

    // R5 line counting
    cfg(2, 1, 3, 1'b0);
    seen = 0; arm();
    pulse(20, 6); pulse(8, 6); pulse(8, 6); settle();
    check("R5 line 2 of 3", seen, 0);
    pulse(30, 6); pulse(8, 6); pulse(8, 6); settle();
    check("R5 vertical clears count", seen, 0);
    pulse(8, 6); settle();
    check("R5 line 3 reached", seen, 1);

    // R6 line 0
    cfg(2, 1, 0, 1'b0);
    seen = 0; arm();
    pulse(8, 6); pulse(8, 6); settle();
    check("R6 horizontal no match", seen, 0);
    pulse(20, 6); settle();
    check("R6 vertical match", seen, 1);

    // R7 inverted vertical polarity
    cfg(3, 1, 0, 1'b1);
    seen = 0; arm();
    pulse(10, 6); settle();
    check("R7 short low pulse", seen, 0);
    pulse(30, 6); settle();
    check("R7 long low pulse", seen, 1);

    // R9 arm coincides with pulse end
    cfg(3, 1, 0, 1'b0);
    seen = 0; arm();
    te_i = 1'b1;
    repeat (20) @(negedge clk_i);
    te_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    settle();
    check("R9 collision no match", seen, 0);
    check("R9 collision xfer", int'(xfer_en_o), 0);
    pulse(20, 6); settle();
    check("R9 still armed", seen, 1);

    // R10 divider by 4
    div_i = 3'd3;
    cfg(3, 1, 0, 1'b0);
    seen = 0; arm();
    pulse(50, 8); settle();
    check("R10 50 cycles below 16 ticks", seen, 0);
    pulse(80, 8); settle();
    check("R10 80 cycles above 16 ticks", seen, 1);
    div_i = 3'd0;

    // random trains against model
    cfg(0, 0, 0, 1'b0);
    lc = 0;
    for (int t = 0; t < 40; t++) begin
      int md, en, ln, np, xp, mp;
      bit son, armed;
      logic pol;
      case ($urandom % 5)
        0: md = 0;
        1, 2: md = 2;
        default: md = 3;
      endcase
      en  = (($urandom % 6) != 0) ? 1 : 0;
      ln  = int'($urandom % 4);
      pol = logic'($urandom % 2);
      cfg(md, en, ln, pol);
      son = (en == 1) && (md >= 2);
      if (!son) lc = 0;
      seen = 0; arm();
      armed = son; xp = son ? 0 : 1; mp = 0;
      np = 1 + int'($urandom % 6);
      for (int p = 0; p < np; p++) begin
        int cls, w;
        cls = int'($urandom % 3);
        w = (cls == 0) ? 1 + int'($urandom % 2) :
            (cls == 1) ? 5 + int'($urandom % 8) : 20 + int'($urandom % 21);
        pulse(w, 4 + int'($urandom % 7));
        if (son) begin
          if (classify(w) == 2) begin
            lc = 0;
            if (armed && (md == 3 || ln == 0)) begin mp++; armed = 0; xp = 1; end
          end else if (classify(w) == 1) begin
            if (lc < 2047) lc++;
            if (armed && md == 2 && ln != 0 && lc == ln) begin mp++; armed = 0; xp = 1; end
          end
        end
      end
      settle();
      if (!son) begin
        check("R2 random match", seen, mp);
        check("R2 random xfer", int'(xfer_en_o), xp);
      end else if (md == 2 && ln != 0) begin
        check("R5 random match", seen, mp);
        check("R5 random xfer", int'(xfer_en_o), xp);
      end else begin
        check("R3 random match", seen, mp);
        check("R3 random xfer", int'(xfer_en_o), xp);
      end
    end

    check("R11 longest match run", run_max, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule